// File: doc/BRIEF.md
# Timeslot-gated PRBS test pattern inserter

This block produces a pseudo-random binary test sequence and places it in selected timeslots of a framed 2.048 Mbit/s serial stream. The frame has 32 timeslots of 8 bits, and the bits of each slot go out most significant bit first. The block runs on the bit clock. A frame sync pulse marks the first bit of timeslot 0. In every bit period the block chooses between the bit from the normal transmit path and the next bit of the test sequence. The result leaves through a single output register.

A 6-bit code chooses the slots that carry the sequence. One code covers every slot except slot 0. Another code covers all 32 slots. Codes 1 to 31 each select a single slot, and the remaining codes insert nothing. A length bit chooses between a 2^15-1 sequence and a 2^20-1 sequence. The shift register moves forward only in bit periods where the block actually sends a sequence bit, so the pattern continues without a break across the unselected gaps and across frame boundaries. The receiving analyzer therefore sees one unbroken sequence.

Top module: `prbs_slot_inserter`

## Requirements
- R1: During reset `tx_out` is 0, and the generator state is loaded with all ones.
- R2: While `gen_en` is 0, `tx_out` equals `tx_in` delayed by one clock, whatever the other inputs are.
- R3: A cycle with `fsync` high is bit 0 of slot 0. Slot k then spans frame bit positions 8k to 8k+7. Until the first `fsync` after reset, nothing is inserted.
- R4: Code 6'd0 inserts sequence bits in slots 1 to 31 and passes slot 0 through.
- R5: Code 6'd32 inserts sequence bits in all 32 slots.
- R6: A code from 6'd1 to 6'd31 inserts sequence bits only in the slot with that number.
- R7: Codes 6'd33 to 6'd63 insert nothing, so the output is `tx_in` delayed by one clock.
- R8: With `long_seq` 0 the sequence is x^15+x^14+1. With output bit b[n], b[n+15] = b[n] xor b[n+1], and the first 15 bits after seeding are ones.
- R9: With `long_seq` 1 the sequence is x^20+x^17+1. Here b[n+20] = b[n] xor b[n+3], and the first 20 bits after seeding are ones.
- R10: The generator advances only on bits it inserts, so the sequence continues across unselected slots and frame boundaries.
- R11: Every clock with `gen_en` 0 reloads the all-ones seed, so each enable restarts the sequence from its first bit. `long_seq` may change only while `gen_en` is 0.
- R12: The generator state is never all zeros.
- R13: An `fsync` in mid-frame realigns the bit position to bit 0 of slot 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High for the first bit of slot 0 |
| gen_en | input | 1 | Generator enable |
| slot_sel | input | 6 | Timeslot selection code |
| long_seq | input | 1 | 0: 2^15-1 sequence, 1: 2^20-1 sequence |
| tx_in | input | 1 | Normal transmit data |
| tx_out | output | 1 | Transmit data with test bits inserted, one clock of latency |

## Verification
The bench builds the block with its default parameters: 32 slots of 8 bits, a 15-bit short register with its tap at 14, and a 20-bit long register with its tap at 17. With these values the frame is only 256 bit periods long, so a run in the all-slots mode goes through a complete 32767-bit short period in about 128 frames. The same run covers the single-slot, skip-slot-0 and reserved codes, a realignment in mid-frame, and a restart after disable in long mode.

// File: rtl/prbs_slot_inserter.sv
module prbs_slot_inserter #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int SEL_W     = 6,
  parameter int SHORT_LEN = 15,
  parameter int SHORT_TAP = 14,
  parameter int LONG_LEN  = 20,
  parameter int LONG_TAP  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             gen_en,
  input  logic [SEL_W-1:0] slot_sel,
  input  logic             long_seq,
  input  logic             tx_in,
  output logic             tx_out
);

  localparam int POS_W    = $clog2(SLOTS * SLOT_BITS);
  localparam int BIT_W    = $clog2(SLOT_BITS);
  localparam int SLOT_W   = POS_W - BIT_W;
  localparam int ALL_CODE = 1 << (SEL_W - 1);

  logic [POS_W-1:0]    pos_q, cur_pos;
  logic                aligned_q, aligned;
  logic [SLOT_W-1:0]   cur_slot;
  logic                code_skip0, code_all, code_one, slot_hit, ins;
  logic [LONG_LEN-1:0] lfsr_q;
  logic                prbs_bit, fb;

  assign cur_pos  = fsync ? '0 : pos_q + 1'b1;
  assign aligned  = fsync | aligned_q;
  assign cur_slot = cur_pos[POS_W-1:BIT_W];

  assign code_skip0 = (slot_sel == '0);
  assign code_all   = (slot_sel == SEL_W'(ALL_CODE));
  assign code_one   = !code_skip0 && (int'(slot_sel) < SLOTS);
  assign slot_hit   = code_all
                    | (code_skip0 && cur_slot != '0)
                    | (code_one && SEL_W'(cur_slot) == slot_sel);
  assign ins        = gen_en & aligned & slot_hit;

  assign prbs_bit = long_seq ? lfsr_q[LONG_LEN-1] : lfsr_q[SHORT_LEN-1];
  assign fb       = long_seq ? lfsr_q[LONG_LEN-1] ^ lfsr_q[LONG_TAP-1]
                             : lfsr_q[SHORT_LEN-1] ^ lfsr_q[SHORT_TAP-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
      lfsr_q    <= '1;
      tx_out    <= 1'b0;
    end else begin
      pos_q     <= cur_pos;
      aligned_q <= aligned;
      if (!gen_en)
        lfsr_q <= '1;
      else if (ins)
        lfsr_q <= {lfsr_q[LONG_LEN-2:0], fb};
      tx_out    <= ins ? prbs_bit : tx_in;
    end
  end

endmodule

// File: rtl/prbs_slot_inserter_chk.sv
module prbs_slot_inserter_chk #(
  parameter int SEL_W    = 6,
  parameter int SLOT_W   = 5,
  parameter int LFSR_W   = 20,
  parameter int ALL_CODE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_en,
  input logic [SEL_W-1:0]  slot_sel,
  input logic              tx_in,
  input logic              tx_out,
  input logic [SLOT_W-1:0] cur_slot,
  input logic              aligned,
  input logic              ins,
  input logic [LFSR_W-1:0] lfsr_q
);

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> tx_out == $past(tx_in));

  p_unaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !ins);

  p_ts0_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel == '0 && cur_slot == '0) |-> !ins);

  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel != '0 && int'(slot_sel) < ALL_CODE && ins) |-> SEL_W'(cur_slot) == slot_sel);

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && int'(slot_sel) > ALL_CODE) |=> tx_out == $past(tx_in));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !ins) |=> $stable(lfsr_q));

  p_reseed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> &lfsr_q);

  p_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    |lfsr_q);

endmodule

bind prbs_slot_inserter prbs_slot_inserter_chk #(
  .SEL_W(SEL_W), .SLOT_W(SLOT_W), .LFSR_W(LONG_LEN), .ALL_CODE(ALL_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .slot_sel(slot_sel),
  .tx_in(tx_in), .tx_out(tx_out), .cur_slot(cur_slot), .aligned(aligned),
  .ins(ins), .lfsr_q(lfsr_q)
);

// File: tb/tb_prbs_slot_inserter.sv
module tb_prbs_slot_inserter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, fsync = 1'b0, gen_en = 1'b0, long_seq = 1'b0, tx_in = 1'b0;
  logic [5:0] slot_sel = '0;
  logic       tx_out;

  prbs_slot_inserter dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .gen_en(gen_en),
    .slot_sel(slot_sel), .long_seq(long_seq), .tx_in(tx_in), .tx_out(tx_out)
  );

  int    checks = 0, fails = 0;
  string req = "R1";
  bit    q[$];
  int    pos = 0, fcnt = 0;
  bit    aligned = 0;

  function automatic bit hit(int s, int code);
    if (code == 0)  return s != 0;
    if (code == 32) return 1;
    if (code < 32)  return s == code;
    return 0;
  endfunction

  function automatic void seed();
    q.delete();
    repeat (long_seq ? 20 : 15) q.push_back(1'b1);
  endfunction

  task automatic check(bit act, bit exp, string r);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", r, $time, act, exp);
    end
  endtask

  task automatic cyc();
    bit exp;
    @(negedge clk);
    fsync = (fcnt == 0);
    tx_in = 1'($urandom);
    fcnt  = (fcnt + 1) % 256;
    @(posedge clk);
    if (fsync) begin pos = 0; aligned = 1; end
    else if (aligned) pos = (pos + 1) % 256;
    if (!gen_en) begin
      seed();
      exp = tx_in;
    end else if (aligned && hit(pos / 8, int'(slot_sel))) begin
      exp = q[0];
      q.push_back(q[0] ^ q[long_seq ? 3 : 1]);
      void'(q.pop_front());
    end else exp = tx_in;
    #1 check(tx_out, exp, req);
  endtask

  task automatic run(int n, string r);
    req = r;
    repeat (n) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: output low and seed loaded during reset
    gen_en = 1'b1; slot_sel = 6'd32; fcnt = 1;
    repeat (3) begin
      @(negedge clk);
      check(tx_out, 1'b0, "R1");
    end
    seed();
    @(negedge clk) rst_n = 1'b1;
    run(300, "R3");        // no insertion before the first frame sync
    run(33000, "R8");      // a full short period in all slots; also R12
    slot_sel = 6'd0;  run(768, "R4");
    slot_sel = 6'd5;  run(768, "R10");
    slot_sel = 6'd31; run(512, "R6");
    slot_sel = 6'd1;  run(512, "R6");
    slot_sel = 6'd33; run(512, "R7");
    slot_sel = 6'd63; run(256, "R7");
    gen_en = 1'b0; slot_sel = 6'd32; run(600, "R2");
    long_seq = 1'b1; run(20, "R11");
    gen_en = 1'b1; run(300, "R11");
    run(3000, "R9");
    run(512, "R5");
    slot_sel = 6'd3; fcnt = 77; run(800, "R13");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule